// File: doc/BRIEF.md
# Banked Indirect Operand Address Generator

This block turns a register-indirect memory operand of a 16-bit processor with a 24-bit banked address space into a 24-bit effective address. It then fetches the operand through a byte-wide memory port. Decode supplies the pointer register number and its contents, an addressing-mode code, a signed displacement and a byte/word size flag. The four bank bytes (data, additional data, system stack, user stack) and the stack-select flag come from the processor state. In the 16-bit pointer modes, the top address byte comes from the bank register tied to the pointer number. In long mode, the top byte comes from the pointer register itself.

The block reads the operand one byte per beat, low byte first, and presents the assembled value. For post-increment operands it also returns the advanced pointer value with a write-back strobe. The register file then stores that value.

The sequencer has five states:
- IDLE waits for `start`. A legal request moves it to LO_BEAT and latches the address. An illegal request moves it to FAULT.
- LO_BEAT requests the byte at the effective address. On `mem_ready` it moves to DONE for a byte access or to HI_BEAT for a word access.
- HI_BEAT requests the following byte. On `mem_ready` it moves to DONE.
- DONE presents the result for one cycle and then returns to IDLE.
- FAULT flags the rejected request for one cycle and then returns to IDLE.

Top module: `bank_ea_gen`

## Requirements
- R1: With mode code 2'b00 (8-bit displacement), 2'b01 (16-bit displacement) or 2'b10 (post-increment), pointer registers 0, 1, 4 and 5 place `bank_dat` in address bits 23..16.
- R2: In the same three modes, pointer registers 2 and 6 place `bank_add` in address bits 23..16.
- R3: In the same three modes, pointer registers 3 and 7 place `bank_ssp` in bits 23..16 when `sys_stack` is 1, and `bank_usp` when it is 0.
- R4: Mode 2'b00 adds `disp[7:0]`, sign-extended, to `reg_val[15:0]` modulo 65536 for any register 0..7. The bank byte is never altered by a carry or a borrow.
- R5: Mode 2'b01 adds the full 16-bit `disp` to `reg_val[15:0]` modulo 65536.
- R6: Mode 2'b11 (long pointer) forms the address as `reg_val[23:0]` plus sign-extended `disp[7:0]`, modulo 2^24, and uses no bank register.
- R7: Mode 2'b10 accesses the address formed from the unmodified pointer. In the result cycle it raises `wb_en` with `wb_idx` equal to the pointer number. `wb_val` is the pointer plus 2 for a word access or plus 1 for a byte access (`byte_op`=1), modulo 65536. No other mode raises `wb_en`.
- R8: A word is read as two beats: first the effective address, then the effective address plus 1 modulo 2^24. `rd_data[7:0]` is the first byte and `rd_data[15:8]` is the second. A byte access makes one beat and returns the byte zero-extended.
- R9: `mem_req` stays high and `mem_addr` stays stable until `mem_ready` is seen. Each beat transfers one byte.
- R10: `rd_valid` is high for exactly the one cycle after the cycle in which the last beat's `mem_ready` is seen.
- R11: Modes 2'b01, 2'b10 and 2'b11 accept only registers 0..3. Any other combination makes no memory request and no write-back, and pulses `op_fault` for one cycle.
- R12: `start` is ignored while `busy` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Request strobe, sampled when idle |
| mode | input | 2 | Addressing mode code |
| byte_op | input | 1 | 1 = byte access, 0 = word access |
| reg_idx | input | 3 | Pointer register number |
| reg_val | input | 32 | Pointer register contents (low 16 bits used in 16-bit modes) |
| disp | input | 16 | Displacement (low 8 bits in 8-bit forms) |
| bank_dat | input | 8 | Data bank byte |
| bank_add | input | 8 | Additional data bank byte |
| bank_ssp | input | 8 | System stack bank byte |
| bank_usp | input | 8 | User stack bank byte |
| sys_stack | input | 1 | 1 selects the system stack bank, 0 the user stack bank |
| busy | output | 1 | High in every state except IDLE |
| op_fault | output | 1 | One-cycle pulse for a rejected request |
| ea | output | 24 | Latched effective address |
| mem_req | output | 1 | Byte read request |
| mem_addr | output | 24 | Byte read address |
| mem_ready | input | 1 | Byte returned this cycle |
| mem_rdata | input | 8 | Returned byte |
| rd_valid | output | 1 | Operand result valid |
| rd_data | output | 16 | Assembled operand |
| wb_en | output | 1 | Pointer write-back strobe |
| wb_idx | output | 3 | Register number to write back |
| wb_val | output | 16 | Advanced pointer value |

## Verification
The assertions guard the memory handshake and the result timing on every cycle:
- the request and its address stay stable while a beat is pending;
- a result appears only right after an accepted beat;
- a write-back never occurs without a result;
- a fault never coincides with a request.

Only the bench scenarios can show the arithmetic. These cover bank choice per register and stack flag, sign extension and 16-bit wrap inside a bank, and 24-bit wrap in long mode. They also cover the pointer advance for byte and word accesses, the byte order across the 2^24 boundary, and the rejection of oversize register numbers and of a `start` issued while busy.

// File: rtl/bea_pkg.sv
package bea_pkg;
    typedef enum logic [1:0] {
        AM_DISP8   = 2'b00,
        AM_DISP16  = 2'b01,
        AM_POSTINC = 2'b10,
        AM_LONG    = 2'b11
    } am_e;

    typedef enum logic [2:0] {
        S_IDLE    = 3'd0,
        S_LO_BEAT = 3'd1,
        S_HI_BEAT = 3'd2,
        S_DONE    = 3'd3,
        S_FAULT   = 3'd4
    } seq_st_e;
endpackage

// File: rtl/bea_addr_calc.sv
module bea_addr_calc
    import bea_pkg::*;
#(
    parameter int PTR_W   = 16,
    parameter int BANK_W  = 8,
    parameter int LPTR_W  = 32,
    parameter int NREG    = 8,
    parameter int WIDE_RG = 4,
    localparam int ADDR_W = PTR_W + BANK_W,
    localparam int IDX_W  = $clog2(NREG),
    localparam int SHORT_W = 8
) (
    input  am_e               mode,
    input  logic              byte_op,
    input  logic [IDX_W-1:0]  idx,
    input  logic [LPTR_W-1:0] ptr,
    input  logic [PTR_W-1:0]  disp,
    input  logic [BANK_W-1:0] bank_dat,
    input  logic [BANK_W-1:0] bank_add,
    input  logic [BANK_W-1:0] bank_ssp,
    input  logic [BANK_W-1:0] bank_usp,
    input  logic              sys_stack,
    output logic [ADDR_W-1:0] ea,
    output logic [PTR_W-1:0]  ptr_next,
    output logic              legal,
    output logic              wb_req
);
    logic [BANK_W-1:0] bank_sel;
    logic [PTR_W-1:0]  short_off;
    logic [PTR_W-1:0]  low_sum;
    logic [ADDR_W-1:0] long_sum;

    always_comb begin
        unique case (idx[1:0])
            2'b00, 2'b01: bank_sel = bank_dat;
            2'b10:        bank_sel = bank_add;
            default:      bank_sel = sys_stack ? bank_ssp : bank_usp;
        endcase
    end

    assign short_off = {{(PTR_W-SHORT_W){disp[SHORT_W-1]}}, disp[SHORT_W-1:0]};

    always_comb begin
        unique case (mode)
            AM_DISP8:  low_sum = ptr[PTR_W-1:0] + short_off;
            AM_DISP16: low_sum = ptr[PTR_W-1:0] + disp;
            default:   low_sum = ptr[PTR_W-1:0];
        endcase
    end

    assign long_sum = ptr[ADDR_W-1:0]
                    + {{(ADDR_W-SHORT_W){disp[SHORT_W-1]}}, disp[SHORT_W-1:0]};

    assign ea       = (mode == AM_LONG) ? long_sum : {bank_sel, low_sum};
    assign ptr_next = ptr[PTR_W-1:0] + (byte_op ? PTR_W'(1) : PTR_W'(2));
    assign legal    = (mode == AM_DISP8) || (int'(idx) < WIDE_RG);
    assign wb_req   = (mode == AM_POSTINC);
endmodule

// File: rtl/bea_read_seq.sv
module bea_read_seq
    import bea_pkg::*;
#(
    parameter int ADDR_W = 24,
    parameter int PTR_W  = 16,
    parameter int IDX_W  = 3,
    localparam int BYTE_W = 8,
    localparam int WORD_W = 2 * BYTE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              legal,
    input  logic              byte_op,
    input  logic              wb_req,
    input  logic [IDX_W-1:0]  idx,
    input  logic [ADDR_W-1:0] ea_in,
    input  logic [PTR_W-1:0]  ptr_next,
    output logic              busy,
    output logic              op_fault,
    output logic [ADDR_W-1:0] ea,
    output logic              mem_req,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic              mem_ready,
    input  logic [BYTE_W-1:0] mem_rdata,
    output logic              rd_valid,
    output logic [WORD_W-1:0] rd_data,
    output logic              wb_en,
    output logic [IDX_W-1:0]  wb_idx,
    output logic [PTR_W-1:0]  wb_val
);
    seq_st_e state, state_nx;
    logic [ADDR_W-1:0] ea_q;
    logic [BYTE_W-1:0] lo_q, hi_q;
    logic              byte_q, wb_q;
    logic [IDX_W-1:0]  idx_q;
    logic [PTR_W-1:0]  wbv_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            S_IDLE:    if (start) state_nx = legal ? S_LO_BEAT : S_FAULT;
            S_LO_BEAT: if (mem_ready) state_nx = byte_q ? S_DONE : S_HI_BEAT;
            S_HI_BEAT: if (mem_ready) state_nx = S_DONE;
            S_DONE:    state_nx = S_IDLE;
            S_FAULT:   state_nx = S_IDLE;
            default:   state_nx = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ea_q   <= '0;
            lo_q   <= '0;
            hi_q   <= '0;
            byte_q <= 1'b0;
            wb_q   <= 1'b0;
            idx_q  <= '0;
            wbv_q  <= '0;
        end else begin
            if (state == S_IDLE && start && legal) begin
                ea_q   <= ea_in;
                byte_q <= byte_op;
                wb_q   <= wb_req;
                idx_q  <= idx;
                wbv_q  <= ptr_next;
            end
            if (state == S_LO_BEAT && mem_ready) lo_q <= mem_rdata;
            if (state == S_HI_BEAT && mem_ready) hi_q <= mem_rdata;
        end
    end

    always_comb begin
        mem_req  = 1'b0;
        mem_addr = ea_q;
        rd_valid = 1'b0;
        op_fault = 1'b0;
        wb_en    = 1'b0;
        unique case (state)
            S_IDLE: ;
            S_LO_BEAT: mem_req = 1'b1;
            S_HI_BEAT: begin
                mem_req  = 1'b1;
                mem_addr = ea_q + {{(ADDR_W-1){1'b0}}, 1'b1};
            end
            S_DONE: begin
                rd_valid = 1'b1;
                wb_en    = wb_q;
            end
            S_FAULT: op_fault = 1'b1;
            default: ;
        endcase
    end

    assign busy    = (state != S_IDLE);
    assign ea      = ea_q;
    assign rd_data = byte_q ? {{BYTE_W{1'b0}}, lo_q} : {hi_q, lo_q};
    assign wb_idx  = idx_q;
    assign wb_val  = wbv_q;

    assert_req_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ready) |=> (mem_req && $stable(mem_addr)));
    assert_result_after_beat_R10: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> $past(mem_ready));
    assert_result_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |=> !rd_valid);
    assert_wb_with_result_R7: assert property (@(posedge clk) disable iff (!rst_n)
        wb_en |-> rd_valid);
    assert_fault_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
        op_fault |-> (!mem_req && !wb_en && !rd_valid));
    assert_exclusive_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({mem_req, rd_valid, op_fault}));
endmodule

// File: rtl/bank_ea_gen.sv
module bank_ea_gen
    import bea_pkg::*;
#(
    parameter int PTR_W   = 16,
    parameter int BANK_W  = 8,
    parameter int LPTR_W  = 32,
    parameter int NREG    = 8,
    parameter int WIDE_RG = 4,
    localparam int ADDR_W = PTR_W + BANK_W,
    localparam int IDX_W  = $clog2(NREG)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [1:0]        mode,
    input  logic              byte_op,
    input  logic [IDX_W-1:0]  reg_idx,
    input  logic [LPTR_W-1:0] reg_val,
    input  logic [PTR_W-1:0]  disp,
    input  logic [BANK_W-1:0] bank_dat,
    input  logic [BANK_W-1:0] bank_add,
    input  logic [BANK_W-1:0] bank_ssp,
    input  logic [BANK_W-1:0] bank_usp,
    input  logic              sys_stack,
    output logic              busy,
    output logic              op_fault,
    output logic [ADDR_W-1:0] ea,
    output logic              mem_req,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic              mem_ready,
    input  logic [7:0]        mem_rdata,
    output logic              rd_valid,
    output logic [15:0]       rd_data,
    output logic              wb_en,
    output logic [IDX_W-1:0]  wb_idx,
    output logic [PTR_W-1:0]  wb_val
);
    logic [ADDR_W-1:0] ea_calc;
    logic [PTR_W-1:0]  ptr_next;
    logic              legal, wb_req;

    bea_addr_calc #(
        .PTR_W(PTR_W), .BANK_W(BANK_W), .LPTR_W(LPTR_W),
        .NREG(NREG), .WIDE_RG(WIDE_RG)
    ) u_calc (
        .mode(am_e'(mode)), .byte_op(byte_op), .idx(reg_idx), .ptr(reg_val),
        .disp(disp), .bank_dat(bank_dat), .bank_add(bank_add),
        .bank_ssp(bank_ssp), .bank_usp(bank_usp), .sys_stack(sys_stack),
        .ea(ea_calc), .ptr_next(ptr_next), .legal(legal), .wb_req(wb_req)
    );

    bea_read_seq #(.ADDR_W(ADDR_W), .PTR_W(PTR_W), .IDX_W(IDX_W)) u_seq (
        .clk(clk), .rst_n(rst_n), .start(start), .legal(legal),
        .byte_op(byte_op), .wb_req(wb_req), .idx(reg_idx), .ea_in(ea_calc),
        .ptr_next(ptr_next), .busy(busy), .op_fault(op_fault), .ea(ea),
        .mem_req(mem_req), .mem_addr(mem_addr), .mem_ready(mem_ready),
        .mem_rdata(mem_rdata), .rd_valid(rd_valid), .rd_data(rd_data),
        .wb_en(wb_en), .wb_idx(wb_idx), .wb_val(wb_val)
    );
endmodule

// File: tb/tb_bank_ea_gen.sv
module tb_bank_ea_gen;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [1:0]  mode = 2'b00;
    logic        byte_op = 1'b0;
    logic [2:0]  reg_idx = 3'd0;
    logic [31:0] reg_val = '0;
    logic [15:0] disp = '0;
    logic [7:0]  bank_dat = 8'h78, bank_add = 8'hA5, bank_ssp = 8'h3C, bank_usp = 8'hC3;
    logic        sys_stack = 1'b0;
    logic        busy, op_fault, mem_req, rd_valid, wb_en;
    logic [23:0] ea, mem_addr;
    logic        mem_ready = 1'b0;
    logic [7:0]  mem_rdata = '0;
    logic [15:0] rd_data, wb_val;
    logic [2:0]  wb_idx;

    int checks = 0, errors = 0;
    int lat = 0, wait_cnt = 0, beats = 0;
    logic [23:0] beat_a [2];
    logic [23:0] held;

    typedef struct packed {
        logic        fault;
        logic        byt;
        logic [23:0] ea;
        logic [23:0] a1;
        logic [15:0] data;
        logic        wb;
        logic [2:0]  idx;
        logic [15:0] wbv;
    } exp_t;
    exp_t exp_q[$];

    bank_ea_gen dut (
        .clk(clk), .rst_n(rst_n), .start(start), .mode(mode), .byte_op(byte_op),
        .reg_idx(reg_idx), .reg_val(reg_val), .disp(disp), .bank_dat(bank_dat),
        .bank_add(bank_add), .bank_ssp(bank_ssp), .bank_usp(bank_usp),
        .sys_stack(sys_stack), .busy(busy), .op_fault(op_fault), .ea(ea),
        .mem_req(mem_req), .mem_addr(mem_addr), .mem_ready(mem_ready),
        .mem_rdata(mem_rdata), .rd_valid(rd_valid), .rd_data(rd_data),
        .wb_en(wb_en), .wb_idx(wb_idx), .wb_val(wb_val)
    );

    always #4 clk = ~clk;

    function automatic logic [7:0] memb(logic [23:0] a);
        return a[7:0] ^ {a[11:8], a[15:12]} ^ a[23:16] ^ 8'h5A;
    endfunction

    task automatic chk(string req, string what, logic [31:0] act, logic [31:0] expv);
        checks++;
        if (act !== expv) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, expv);
        end
    endtask

    function automatic exp_t predict(logic [1:0] m, logic b, logic [2:0] i,
                                     logic [31:0] p, logic [15:0] d, logic s);
        exp_t e;
        logic [7:0]  bk;
        logic [15:0] lo;
        e = '0;
        e.fault = !((m == 2'b00) || (i < 3'd4));
        case (i[1:0])
            2'b00, 2'b01: bk = bank_dat;
            2'b10:        bk = bank_add;
            default:      bk = s ? bank_ssp : bank_usp;
        endcase
        case (m)
            2'b00:   lo = p[15:0] + {{8{d[7]}}, d[7:0]};
            2'b01:   lo = p[15:0] + d;
            default: lo = p[15:0];
        endcase
        e.ea   = (m == 2'b11) ? p[23:0] + {{16{d[7]}}, d[7:0]} : {bk, lo};
        e.a1   = e.ea + 24'd1;
        e.byt  = b;
        e.data = b ? {8'h00, memb(e.ea)} : {memb(e.a1), memb(e.ea)};
        e.wb   = (m == 2'b10);
        e.idx  = i;
        e.wbv  = p[15:0] + (b ? 16'd1 : 16'd2);
        return e;
    endfunction

    // memory responder with programmable latency, checks address hold (R9)
    always @(negedge clk) begin
        if (mem_ready) mem_ready = 1'b0;
        else if (mem_req) begin
            if (wait_cnt < lat) begin
                if (wait_cnt > 0) chk("R9", "address held while waiting", mem_addr, held);
                held = mem_addr;
                wait_cnt++;
            end else begin
                mem_ready = 1'b1;
                mem_rdata = memb(mem_addr);
                if (beats < 2) beat_a[beats] = mem_addr;
                beats++;
                wait_cnt = 0;
            end
        end
    end

    // scoreboard monitor
    always @(negedge clk) begin
        if (rst_n && (rd_valid || op_fault)) begin
            if (exp_q.size() == 0) begin
                chk("R12", "unexpected output", {30'd0, rd_valid, op_fault}, 32'd0);
            end else begin
                exp_t e;
                e = exp_q.pop_front();
                chk("R11", "fault flag", op_fault, e.fault);
                if (e.fault) begin
                    chk("R11", "no beats on fault", beats, 0);
                    chk("R11", "no write-back on fault", wb_en, 1'b0);
                end else begin
                    chk("R1-6", "effective address", ea, e.ea);
                    chk("R8", "beat count", beats, e.byt ? 1 : 2);
                    chk("R8", "first beat address", beat_a[0], e.ea);
                    if (!e.byt) chk("R8", "second beat address", beat_a[1], e.a1);
                    chk("R8", "assembled data", rd_data, e.data);
                    chk("R7", "write-back strobe", wb_en, e.wb);
                    if (e.wb) begin
                        chk("R7", "write-back index", wb_idx, e.idx);
                        chk("R7", "write-back value", wb_val, e.wbv);
                    end
                end
            end
            beats = 0;
        end
    end

    // R10: result exactly one cycle after last ready, and only once
    logic ready_d = 1'b0;
    always @(posedge clk) begin
        #1;
        if (rd_valid) chk("R10", "ready seen in prior cycle", ready_d, 1'b1);
    end
    always @(posedge clk) ready_d <= mem_ready;

    task automatic issue(logic [1:0] m, logic b, logic [2:0] i, logic [31:0] p,
                         logic [15:0] d, logic s, int l, logic poke);
        @(negedge clk);
        lat = l;
        mode = m; byte_op = b; reg_idx = i; reg_val = p; disp = d; sys_stack = s;
        exp_q.push_back(predict(m, b, i, p, d, s));
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        if (poke) begin
            // R12: an illegal request while busy must be ignored
            mode = 2'b01; reg_idx = 3'd7; start = 1'b1;
            @(negedge clk);
            start = 1'b0;
        end
        while (busy) @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual hung expected done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R10", "reset rd_valid", rd_valid, 1'b0);
        chk("R9", "reset mem_req", mem_req, 1'b0);
        chk("R11", "reset op_fault", op_fault, 1'b0);
        chk("R7", "reset wb_en", wb_en, 1'b0);
        chk("R12", "reset busy", busy, 1'b0);
        rst_n = 1'b1;
        // R1 R4: data bank with positive 8-bit displacement
        issue(2'b00, 1'b0, 3'd1, 32'h0000D30F, 16'h0010, 1'b0, 0, 1'b0);
        issue(2'b00, 1'b0, 3'd5, 32'h00001234, 16'h0001, 1'b0, 2, 1'b0);
        // R2 R4: additional bank, negative displacement wrapping below zero
        issue(2'b00, 1'b0, 3'd2, 32'h00000010, 16'h0080, 1'b0, 1, 1'b0);
        issue(2'b00, 1'b1, 3'd6, 32'h0000FFF0, 16'h007F, 1'b0, 0, 1'b0);
        // R3: stack bank chosen by flag
        issue(2'b00, 1'b0, 3'd3, 32'h00004000, 16'h0002, 1'b1, 1, 1'b0);
        issue(2'b00, 1'b0, 3'd7, 32'h00004000, 16'h0002, 1'b0, 0, 1'b0);
        // R5: 16-bit displacement wraps within the bank
        issue(2'b01, 1'b0, 3'd0, 32'hABCDFFF0, 16'h0020, 1'b0, 3, 1'b0);
        issue(2'b01, 1'b0, 3'd3, 32'h00001000, 16'h8000, 1'b1, 0, 1'b0);
        // R6: long pointer, sign-extended 8-bit displacement, 24-bit wrap
        issue(2'b11, 1'b0, 3'd2, 32'hF3824B02, 16'h0025, 1'b0, 1, 1'b0);
        issue(2'b11, 1'b0, 3'd1, 32'h00FFFFFF, 16'h0001, 1'b0, 0, 1'b0);
        issue(2'b11, 1'b1, 3'd0, 32'h12000000, 16'h00FF, 1'b0, 0, 1'b0);
        // R7: post-increment word and byte, pointer wrap
        issue(2'b10, 1'b0, 3'd1, 32'h0000D30F, 16'h0055, 1'b0, 2, 1'b0);
        issue(2'b10, 1'b1, 3'd0, 32'h0000FFFF, 16'h0000, 1'b0, 0, 1'b0);
        issue(2'b10, 1'b0, 3'd3, 32'h0000FFFF, 16'h0000, 1'b1, 1, 1'b0);
        // R8: word crossing the top of the 24-bit space
        bank_dat = 8'hFF;
        issue(2'b00, 1'b0, 3'd4, 32'h0000FFFF, 16'h0000, 1'b0, 1, 1'b0);
        bank_dat = 8'h78;
        // R11: oversize register numbers rejected
        issue(2'b01, 1'b0, 3'd4, 32'h00001000, 16'h0010, 1'b0, 0, 1'b0);
        issue(2'b10, 1'b0, 3'd5, 32'h00001000, 16'h0000, 1'b0, 0, 1'b0);
        issue(2'b11, 1'b0, 3'd6, 32'h00001000, 16'h0001, 1'b0, 0, 1'b0);
        // R12: start while busy ignored
        issue(2'b00, 1'b0, 3'd0, 32'h00002222, 16'h0004, 1'b0, 3, 1'b1);
        repeat (4) @(negedge clk);
        chk("R12", "no leftover expectations", exp_q.size(), 0);
        chk("R12", "idle after poke", busy, 1'b0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule